// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps the time of day and the calendar date as six two-digit BCD fields: seconds, minutes, hours, day of month, month and year. A one-cycle tick enable, expected once per second, advances the seconds. Whenever a field passes its last value, it returns to its first value and passes a carry to the next field up. Every carry in the chain settles in the same clock cycle as the tick. So one tick can move every field at once, for example at the last second of a century.

The day-of-month limit is not fixed. It is worked out from the current month and from a leap-year test on the two-digit year. A load strobe writes all six fields together, for setting the clock, and it wins over a tick in the same cycle. Every field is a register and drives its output port directly. Each output byte holds the tens digit in bits [7:4] and the units digit in bits [3:0].

Top module: `cal_bcd_counter`

## Requirements
- R1: A synchronous reset, active high, sets the time to 00:00:00 and the date to day 01, month 01, year 00.
- R2: The seconds units digit counts 0 to 9 and the tens digit counts 0 to 5. A tick at second 59 gives 00 and carries one into the minutes.
- R3: The minutes count 00 to 59 in the same way. They change only on a tick while the seconds read 59, and minute 59 wraps to 00 with a carry into the hours.
- R4: The hours follow a 24-hour scale. 09 steps to 10, 19 steps to 20, and 23 wraps to 00 with a carry into the day.
- R5: Months 04, 06, 09 and 11 end after day 30. Months 01, 03, 05, 07, 08, 10 and 12 end after day 31. At the end of the last day the day returns to 01 and the month advances.
- R6: Month 02 ends after day 28, or after day 29 when the BCD year is a multiple of four. Year 00 counts as a leap year.
- R7: The month counts 01 to 12. 09 steps to 10, and 12 wraps to 01 with a carry into the year.
- R8: The year counts 00 to 99 in BCD and wraps from 99 to 00.
- R9: When the load strobe is high, all six fields take the load inputs on the next edge. This happens even if the tick is high in the same cycle.
- R10: In a cycle where both the tick and the load strobe are low, no field changes.
- R11: A loaded day is stored as given, without validation. A day value at or above the month's last day wraps to 01, with a month carry, on the next day increment.
- R12: A single tick at 23:59:59 on day 31 of month 12 of year 99 gives 00:00:00 on day 01 of month 01 of year 00 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-second advance enable, one cycle wide |
| load_i | input | 1 | Load strobe for all fields |
| ld_sec_i | input | 8 | BCD seconds to load |
| ld_min_i | input | 8 | BCD minutes to load |
| ld_hour_i | input | 8 | BCD hours to load |
| ld_day_i | input | 8 | BCD day of month to load |
| ld_mon_i | input | 8 | BCD month to load |
| ld_year_i | input | 8 | BCD year to load |
| sec_o | output | 8 | BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | BCD hours |
| day_o | output | 8 | BCD day of month |
| mon_o | output | 8 | BCD month |
| year_o | output | 8 | BCD year |

## Verification
The assertions check on every cycle:
- a field that takes a carry at its terminal value returns to its first value;
- every field stays still when it has neither an increment nor a load;
- a load reaches every field;
- the minutes move only when a tick meets second 59;
- the day limit for February and for the short months is always one of the allowed values.

Only the bench's scenarios can show whether those limits are the right ones for a given month and year. The same holds for the hour steps at 09 and 19, the leap years with an odd tens digit, the wrap of an out-of-range loaded day, and the full cascade of R12 within one cycle.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int DIGIT_W    = 4;
  localparam int FIELD_W    = 2 * DIGIT_W;
  localparam int NUM_FIELDS = 6;

  // Field indices, lowest (first in the carry chain) first
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;
  localparam int F_MON  = 4;
  localparam int F_YEAR = 5;

  typedef logic [FIELD_W-1:0] bcd2_t;

  // First value of a field, also its reset value
  function automatic bcd2_t field_base(input int idx);
    return (idx == F_DAY || idx == F_MON) ? bcd2_t'(8'h01) : bcd2_t'(8'h00);
  endfunction

  // Terminal value of the fixed-limit fields (the day limit is computed)
  function automatic bcd2_t field_limit(input int idx);
    case (idx)
      F_SEC, F_MIN: return bcd2_t'(8'h59);
      F_HOUR:       return bcd2_t'(8'h23);
      F_MON:        return bcd2_t'(8'h12);
      default:      return bcd2_t'(8'h99);
    endcase
  endfunction

  // Two-digit BCD increment
  function automatic bcd2_t bcd_inc(input bcd2_t v);
    logic [DIGIT_W-1:0] lo, hi;
    lo = v[DIGIT_W-1:0];
    hi = v[FIELD_W-1:DIGIT_W];
    if (lo == DIGIT_W'(9)) return {hi + DIGIT_W'(1), DIGIT_W'(0)};
    else                   return {hi, lo + DIGIT_W'(1)};
  endfunction

  // A BCD year is a multiple of four when (10*tens + units) mod 4 == 0
  function automatic logic is_leap(input bcd2_t y);
    logic [DIGIT_W-1:0] lo;
    lo = y[DIGIT_W-1:0];
    if (y[DIGIT_W] == 1'b0)
      return (lo == DIGIT_W'(0)) || (lo == DIGIT_W'(4)) || (lo == DIGIT_W'(8));
    else
      return (lo == DIGIT_W'(2)) || (lo == DIGIT_W'(6));
  endfunction
endpackage

// File: rtl/cal_day_limit.sv
module cal_day_limit
  import cal_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  bcd2_t mon_i,
  input  bcd2_t year_i,
  output bcd2_t last_o
);
  logic leap;
  assign leap = is_leap(year_i);

  always_comb begin
    case (mon_i)
      8'h02:                      last_o = leap ? bcd2_t'(8'h29) : bcd2_t'(8'h28);
      8'h04, 8'h06, 8'h09, 8'h11: last_o = bcd2_t'(8'h30);
      default:                    last_o = bcd2_t'(8'h31);
    endcase
  end

  AST_FEB_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (mon_i == 8'h02) |-> (last_o == 8'h28 || last_o == 8'h29)); // R6
  AST_SHORT_MONTH: assert property (@(posedge clk) disable iff (rst)
    (mon_i == 8'h04 || mon_i == 8'h06 || mon_i == 8'h09 || mon_i == 8'h11)
      |-> (last_o == 8'h30)); // R5
endmodule

// File: rtl/cal_field.sv
module cal_field
  import cal_pkg::*;
#(
  parameter bcd2_t BASE = '0
)(
  input  logic  clk,
  input  logic  rst,
  input  logic  load_i,
  input  bcd2_t ld_val_i,
  input  logic  inc_i,
  input  bcd2_t limit_i,
  output bcd2_t q_o,
  output logic  at_end_o
);
  bcd2_t q;

  // At or beyond the terminal value: wraps on the next increment
  assign at_end_o = (q >= limit_i);
  assign q_o      = q;

  always_ff @(posedge clk) begin
    if (rst)         q <= BASE;
    else if (load_i) q <= ld_val_i;
    else if (inc_i)  q <= at_end_o ? BASE : bcd_inc(q);
  end

  AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !load_i && at_end_o) |=> (q == BASE)); // R11
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!inc_i && !load_i) |=> $stable(q)); // R10
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (q == $past(ld_val_i))); // R9
endmodule

// File: rtl/cal_bcd_counter.sv
module cal_bcd_counter
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       load_i,
  input  logic [7:0] ld_sec_i,
  input  logic [7:0] ld_min_i,
  input  logic [7:0] ld_hour_i,
  input  logic [7:0] ld_day_i,
  input  logic [7:0] ld_mon_i,
  input  logic [7:0] ld_year_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] day_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o
);
  bcd2_t [NUM_FIELDS-1:0] ld_vec;
  bcd2_t [NUM_FIELDS-1:0] q_vec;
  logic  [NUM_FIELDS-1:0] at_end;
  logic  [NUM_FIELDS-1:0] inc;
  bcd2_t                  day_last;

  assign ld_vec[F_SEC]  = ld_sec_i;
  assign ld_vec[F_MIN]  = ld_min_i;
  assign ld_vec[F_HOUR] = ld_hour_i;
  assign ld_vec[F_DAY]  = ld_day_i;
  assign ld_vec[F_MON]  = ld_mon_i;
  assign ld_vec[F_YEAR] = ld_year_i;

  // Carry chain, settled within the tick cycle
  assign inc[0] = tick_i & ~load_i;

  cal_day_limit u_day_limit (
    .clk    (clk),
    .rst    (rst),
    .mon_i  (q_vec[F_MON]),
    .year_i (q_vec[F_YEAR]),
    .last_o (day_last)
  );

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    bcd2_t limit;
    if (g == F_DAY) begin : g_dyn
      assign limit = day_last;
    end else begin : g_fix
      assign limit = field_limit(g);
    end
    if (g > 0) begin : g_carry
      assign inc[g] = inc[g-1] & at_end[g-1];
    end
    cal_field #(.BASE(field_base(g))) u_field (
      .clk      (clk),
      .rst      (rst),
      .load_i   (load_i),
      .ld_val_i (ld_vec[g]),
      .inc_i    (inc[g]),
      .limit_i  (limit),
      .q_o      (q_vec[g]),
      .at_end_o (at_end[g])
    );
  end

  assign sec_o  = q_vec[F_SEC];
  assign min_o  = q_vec[F_MIN];
  assign hour_o = q_vec[F_HOUR];
  assign day_o  = q_vec[F_DAY];
  assign mon_o  = q_vec[F_MON];
  assign year_o = q_vec[F_YEAR];

  AST_MIN_ONLY_ON_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!$past(load_i) && !$stable(min_o)) |-> ($past(tick_i) && $past(sec_o) == 8'h59)); // R3
  AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (inc[F_YEAR] && at_end[F_YEAR]) |=> (year_o == 8'h00)); // R8
  AST_FULL_ROLL: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !load_i && sec_o == 8'h59 && min_o == 8'h59 && hour_o == 8'h23 &&
     day_o == 8'h31 && mon_o == 8'h12 && year_o == 8'h99)
      |=> (sec_o == 8'h00 && min_o == 8'h00 && hour_o == 8'h00 &&
           day_o == 8'h01 && mon_o == 8'h01 && year_o == 8'h00)); // R12
endmodule

// File: tb/cal_bcd_counter_tb_top.sv
`timescale 1ns/1ps
module cal_bcd_counter_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 1'b0;
  logic load_i = 1'b0;
  logic [7:0] ld_sec_i = '0, ld_min_i = '0, ld_hour_i = '0;
  logic [7:0] ld_day_i = '0, ld_mon_i = '0, ld_year_i = '0;
  logic [7:0] sec_o, min_o, hour_o, day_o, mon_o, year_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  cal_bcd_counter dut_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .load_i(load_i),
    .ld_sec_i(ld_sec_i), .ld_min_i(ld_min_i), .ld_hour_i(ld_hour_i),
    .ld_day_i(ld_day_i), .ld_mon_i(ld_mon_i), .ld_year_i(ld_year_i),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .day_o(day_o), .mon_o(mon_o), .year_o(year_o)
  );

  // Packed state view: {hour, min, sec, day, mon, year}
  function automatic logic [47:0] state_now();
    return {hour_o, min_o, sec_o, day_o, mon_o, year_o};
  endfunction

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive_load(input logic [47:0] s);
    {ld_hour_i, ld_min_i, ld_sec_i, ld_day_i, ld_mon_i, ld_year_i} = s;
    load_i = 1'b1;
  endtask

  // {req, start, expected after one tick}
  localparam int NV = 23;
  localparam logic [99:0] VECS [NV] = '{
    {4'd2,  48'h000000_010100, 48'h000001_010100}, // R2
    {4'd2,  48'h000009_010100, 48'h000010_010100}, // R2
    {4'd2,  48'h000059_010100, 48'h000100_010100}, // R2
    {4'd3,  48'h005959_010100, 48'h010000_010100}, // R3
    {4'd3,  48'h122959_050623, 48'h123000_050623}, // R3
    {4'd4,  48'h095959_010100, 48'h100000_010100}, // R4
    {4'd4,  48'h195959_010100, 48'h200000_010100}, // R4
    {4'd4,  48'h235959_150323, 48'h000000_160323}, // R4
    {4'd5,  48'h235959_300423, 48'h000000_010523}, // R5
    {4'd5,  48'h235959_300123, 48'h000000_310123}, // R5
    {4'd5,  48'h235959_310123, 48'h000000_010223}, // R5
    {4'd7,  48'h235959_300905, 48'h000000_011005}, // R7 R5
    {4'd5,  48'h235959_301123, 48'h000000_011223}, // R5
    {4'd6,  48'h235959_280223, 48'h000000_010323}, // R6
    {4'd6,  48'h235959_280224, 48'h000000_290224}, // R6
    {4'd6,  48'h235959_290224, 48'h000000_010324}, // R6
    {4'd6,  48'h235959_280200, 48'h000000_290200}, // R6
    {4'd6,  48'h235959_280210, 48'h000000_010310}, // R6
    {4'd6,  48'h235959_280212, 48'h000000_290212}, // R6
    {4'd7,  48'h235959_311223, 48'h000000_010124}, // R7
    {4'd12, 48'h235959_311299, 48'h000000_010100}, // R12 R8
    {4'd11, 48'h235959_310423, 48'h000000_010523}, // R11
    {4'd11, 48'h235959_450123, 48'h000000_010223}  // R11
  };

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    step(); step();
    rst = 1'b0;
    check("R1", state_now(), 48'h000000_010100);

    // R10: idle cycles after reset change nothing
    step(); step(); step();
    check("R10", state_now(), 48'h000000_010100);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i][99:96], i);
      drive_load(VECS[i][95:48]);
      step();
      load_i = 1'b0;
      check("R9 load", state_now(), VECS[i][95:48]);
      tick_i = 1'b1;
      step();
      tick_i = 1'b0;
      check(tag, state_now(), VECS[i][47:0]);
    end

    // R9: load wins over a simultaneous tick
    drive_load(48'h115959_150623);
    tick_i = 1'b1;
    step();
    load_i = 1'b0;
    tick_i = 1'b0;
    check("R9 priority", state_now(), 48'h115959_150623);

    // R10: tick low for several cycles holds every field
    step(); step(); step(); step();
    check("R10 hold", state_now(), 48'h115959_150623);

    // R11: out-of-range day is stored as loaded
    drive_load(48'h080000_450799);
    step();
    load_i = 1'b0;
    check("R11 unvalidated", state_now(), 48'h080000_450799);

    // R2 R3: 61 consecutive ticks from 00:00:00
    drive_load(48'h000000_010100);
    step();
    load_i = 1'b0;
    tick_i = 1'b1;
    for (int k = 0; k < 61; k++) step();
    tick_i = 1'b0;
    check("R3 run", state_now(), 48'h000101_010100);

    // R1: reset from a loaded state
    drive_load(48'h235959_311299);
    step();
    load_i = 1'b0;
    rst = 1'b1;
    step();
    rst = 1'b0;
    check("R1 rerst", state_now(), 48'h000000_010100);

    finish_run();
  end
endmodule